// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the device side of a three-wire serial EEPROM with a register array of 16-bit words (256 by default). A host raises the select line and clocks framed commands in on the rising edges of a serial clock. Each frame is a start bit, a two-bit opcode, an address sent most significant bit first, and for writes sixteen data bits. The serial pins are sampled by the system clock through a short synchronizer, and rising serial-clock edges are found by edge detection.

The block supports reading with a leading dummy zero and automatic advance to the following word. It also supports writing a word, erasing a word to all ones, and a write-lock latch that must be unlocked before any change is accepted. Unlocking needs the program-allow input held high. A change runs a self-timed programming cycle whose length is a parameter in system clocks. While that cycle runs, the host can raise select again and read busy (0) or ready (1) on the serial output. Words below a parameter boundary are protected against changes.

Top module: `sereep_slave`

## Requirements
- R1: After reset the output enable is low, the write-lock is engaged, and every word reads as 16'hFFFF.
- R2: A frame begins at the first rising serial-clock edge that sees select and data-in both high. Edges with data-in low before that are ignored.
- R3: After the start bit come two opcode bits and then the address, MSB first. Opcodes are 10 read, 01 write, 11 erase, and 00 for latch control. With 00, the two top address bits select the action: 11 unlocks, 00 locks, and other values do nothing.
- R4: The output enable falls whenever select is low. Otherwise it is high only while read data or programming status is being shown.
- R5: A read drives a 0 after the last address bit, then the 16 bits of the word MSB first, one per rising serial-clock edge.
- R6: While select stays high after a word, the next rising edge starts the word at address+1, which wraps from the top address to 0, with no further dummy bit.
- R7: Write and erase change nothing while the write-lock is engaged. The unlock persists until a lock command.
- R8: Words at addresses below PROTECT_BELOW are never changed by write or erase.
- R9: Write takes 16 data bits and starts programming once select and serial clock are both low. A frame cut short by select falling has no effect.
- R10: Erase sets the addressed word to 16'hFFFF and starts programming when select falls after the address.
- R11: Programming lasts PROG_CYCLES system clocks. During it, a raised select shows 0 on the output and a start bit is ignored. Once it is done, the output shows 1 until the next accepted start bit.
- R12: Unlock, write and erase are accepted only if program-allow is high at every rising edge of their frame.
- R13: After a complete command, further serial-clock edges are ignored until select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from host |
| sdin | input | 1 | Serial data from host |
| pgm_ok | input | 1 | Program-allow input |
| sdout | output | 1 | Serial data or status to host |
| sdout_oe | output | 1 | Output enable for sdout (low means high impedance) |

## Verification
The bench builds the block with PROG_CYCLES=40, so a whole busy window, with polls before and after it ends, fits inside one short frame gap. PROTECT_BELOW=4 puts the protected words within reach of the random address mix. The default 8-bit address lets a sequential read cross the wrap from 8'hFF to 8'h00. The bench keeps SYNC_STAGES=2 and holds each serial-clock phase for eight system clocks, so the output settles well before it is sampled.

// File: rtl/sereep_pkg.sv
package sereep_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_RD, ST_PEND, ST_DONE
   } sstate_t;

   localparam logic [1:0] OP_CTRL  = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] CTRL_UNLOCK = 2'b11;
   localparam logic [1:0] CTRL_LOCK   = 2'b00;
endpackage

// File: rtl/sereep_sampler.sv
module sereep_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sel,
   input  logic sclk,
   input  logic sdin,
   input  logic pgm_ok,
   output logic sel_s,
   output logic sclk_s,
   output logic sdin_s,
   output logic pgm_s,
   output logic sclk_rise
);
   logic [3:0] pipe [SYNC_STAGES];
   logic       sclk_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= '0;
         sclk_d <= 1'b0;
      end else begin
         pipe[0] <= {sel, sclk, sdin, pgm_ok};
         for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
         sclk_d <= pipe[SYNC_STAGES-1][2];
      end
   end

   assign {sel_s, sclk_s, sdin_s, pgm_s} = pipe[SYNC_STAGES-1];
   assign sclk_rise = sclk_s & ~sclk_d;

   // R2
   single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/sereep_timer.sv
module sereep_timer #(
   parameter int CYCLES = 200000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(CYCLES + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (cnt == CW'(CYCLES - 1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
            cnt <= cnt + 1'b1;
         end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
         end
      end
   end

   // R11
   no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start |-> !busy);
endmodule

// File: rtl/sereep_array.sv
module sereep_array #(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 16,
   parameter int PROTECT_BELOW = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] look_addr,
   output logic [DATA_W-1:0] rdata,
   output logic              prot
);
   localparam int WORDS = 1 << ADDR_W;
   localparam logic [ADDR_W:0] PLIM = PROTECT_BELOW[ADDR_W:0];

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[look_addr];

   generate
      if (PROTECT_BELOW == 0) begin : g_noprot
         assign prot = 1'b0;
      end else begin : g_prot
         assign prot = ({1'b0, look_addr} < PLIM);
      end
   endgenerate

   // R8
   prot_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we |-> !({1'b0, waddr} < PLIM));
endmodule

// File: rtl/sereep_slave.sv
module sereep_slave
   import sereep_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 16,
   parameter int PROG_CYCLES   = 200000,
   parameter int PROTECT_BELOW = 0,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sel,
   input  logic sclk,
   input  logic sdin,
   input  logic pgm_ok,
   output logic sdout,
   output logic sdout_oe
);
   localparam int MAXB = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
   localparam int CNT_W = $clog2(MAXB) + 1;

   initial begin
      addr_w_chk: assert (ADDR_W >= 2 && ADDR_W <= 12);
      data_w_chk: assert (DATA_W >= 2);
      cycles_chk: assert (PROG_CYCLES >= 2);
      prot_chk:   assert (PROTECT_BELOW >= 0 && PROTECT_BELOW <= (1 << ADDR_W));
      sync_chk:   assert (SYNC_STAGES >= 1);
   end

   logic sel_s, sclk_s, sdin_s, pgm_s, sclk_rise;
   logic busy, tdone, prog_start, prot;
   logic [DATA_W-1:0] rdata;

   sstate_t           state;
   logic [CNT_W-1:0]  bcnt;
   logic [1:0]        opc;
   logic [ADDR_W-1:0] addr, a_shift, look_addr;
   logic [DATA_W-1:0] shreg;
   logic pe_run, pe_now, unlocked, stat_show, pend_erase, rd_bit;

   sereep_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
      .clk_i, .rst_ni, .sel, .sclk, .sdin, .pgm_ok,
      .sel_s, .sclk_s, .sdin_s, .pgm_s, .sclk_rise
   );

   sereep_timer #(.CYCLES(PROG_CYCLES)) i_timer (
      .clk_i, .rst_ni, .start(prog_start), .busy, .done(tdone)
   );

   sereep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROTECT_BELOW(PROTECT_BELOW)) i_array (
      .clk_i, .rst_ni, .we(tdone), .waddr(addr),
      .wdata(pend_erase ? {DATA_W{1'b1}} : shreg),
      .look_addr, .rdata, .prot
   );

   assign a_shift = {addr[ADDR_W-2:0], sdin_s};
   assign pe_now  = pe_run & pgm_s;

   always_comb begin
      unique case (state)
         ST_ADDR: look_addr = a_shift;
         ST_RD:   look_addr = addr + 1'b1;
         default: look_addr = addr;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state      <= ST_IDLE;
         bcnt       <= '0;
         opc        <= '0;
         addr       <= '0;
         shreg      <= '0;
         pe_run     <= 1'b0;
         unlocked   <= 1'b0;
         stat_show  <= 1'b0;
         pend_erase <= 1'b0;
         rd_bit     <= 1'b0;
         prog_start <= 1'b0;
      end else begin
         prog_start <= 1'b0;
         if (!sel_s) begin
            if (state == ST_PEND) begin
               if (pend_erase || !sclk_s) begin
                  prog_start <= 1'b1;
                  stat_show  <= 1'b1;
                  state      <= ST_IDLE;
               end
            end else begin
               state <= ST_IDLE;
            end
         end else if (sclk_rise) begin
            pe_run <= pe_now;
            unique case (state)
               ST_IDLE: if (sdin_s && !busy) begin
                  state     <= ST_OPC;
                  bcnt      <= '0;
                  pe_run    <= pgm_s;
                  stat_show <= 1'b0;
               end
               ST_OPC: begin
                  opc  <= {opc[0], sdin_s};
                  bcnt <= bcnt + 1'b1;
                  if (bcnt == CNT_W'(1)) begin
                     state <= ST_ADDR;
                     bcnt  <= '0;
                  end
               end
               ST_ADDR: begin
                  addr <= a_shift;
                  bcnt <= bcnt + 1'b1;
                  if (bcnt == CNT_W'(ADDR_W - 1)) begin
                     bcnt <= '0;
                     unique case (opc)
                        OP_READ: begin
                           state  <= ST_RD;
                           rd_bit <= 1'b0;
                           shreg  <= rdata;
                        end
                        OP_WRITE: state <= ST_DATA;
                        OP_ERASE: begin
                           pend_erase <= 1'b1;
                           state <= (unlocked && pe_now && !prot) ? ST_PEND : ST_DONE;
                        end
                        default: begin
                           state <= ST_DONE;
                           if (a_shift[ADDR_W-1 -: 2] == CTRL_UNLOCK && pe_now) unlocked <= 1'b1;
                           if (a_shift[ADDR_W-1 -: 2] == CTRL_LOCK) unlocked <= 1'b0;
                        end
                     endcase
                  end
               end
               ST_DATA: begin
                  shreg <= {shreg[DATA_W-2:0], sdin_s};
                  bcnt  <= bcnt + 1'b1;
                  if (bcnt == CNT_W'(DATA_W - 1)) begin
                     pend_erase <= 1'b0;
                     state <= (unlocked && pe_now && !prot) ? ST_PEND : ST_DONE;
                  end
               end
               ST_RD: begin
                  rd_bit <= shreg[DATA_W-1];
                  shreg  <= {shreg[DATA_W-2:0], 1'b0};
                  bcnt   <= bcnt + 1'b1;
                  if (bcnt == CNT_W'(DATA_W - 1)) begin
                     addr  <= addr + 1'b1;
                     shreg <= rdata;
                     bcnt  <= '0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sdout    <= 1'b0;
         sdout_oe <= 1'b0;
      end else begin
         sdout_oe <= sel_s && ((state == ST_RD) || (state == ST_IDLE && stat_show));
         sdout    <= (state == ST_RD) ? rd_bit : !busy;
      end
   end

   // R4
   hiz_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_s |=> !sdout_oe);
   // R11
   busy_ignores_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |-> state == ST_IDLE);
   // R7
   prog_needs_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prog_start |-> unlocked);
endmodule

// File: tb/test_sereep_slave.sv
module test_sereep_slave;
   localparam int PCYC = 40;
   localparam int PROT = 4;

   logic clk_i = 1'b0, rst_ni = 1'b0;
   logic sel = 1'b0, sclk = 1'b0, sdin = 1'b0, pgm_ok = 1'b0;
   logic sdout, sdout_oe;

   int errs = 0, checks = 0;
   logic smp_do, smp_oe;
   logic [15:0] ref_mem [256];
   bit ref_unl = 1'b0;
   bit ref_stat = 1'b0;

   always #4 clk_i = ~clk_i;

   sereep_slave #(.ADDR_W(8), .DATA_W(16), .PROG_CYCLES(PCYC),
                  .PROTECT_BELOW(PROT), .SYNC_STAGES(2)) i_sereep_slave (
      .clk_i, .rst_ni, .sel, .sclk, .sdin, .pgm_ok, .sdout, .sdout_oe
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit will_accept(input logic [7:0] a, input bit pe_all);
      return ref_unl && pe_all && (a >= PROT);
   endfunction

   task automatic clk_bit(input logic b);
      sdin = b;
      repeat (4) @(negedge clk_i);
      sclk = 1'b1;
      repeat (8) @(negedge clk_i);
      smp_do = sdout;
      smp_oe = sdout_oe;
      sclk = 1'b0;
      repeat (4) @(negedge clk_i);
   endtask

   task automatic sel_up();
      sel = 1'b1;
      repeat (4) @(negedge clk_i);
   endtask

   task automatic sel_down();
      sclk = 1'b0;
      sel = 1'b0;
      repeat (6) @(negedge clk_i);
   endtask

   task automatic send_hdr(input logic [1:0] op, input logic [7:0] a, input logic pe_v);
      pgm_ok = pe_v;
      clk_bit(1'b1);
      ref_stat = 1'b0;
      clk_bit(op[1]);
      clk_bit(op[0]);
      for (int i = 7; i >= 0; i--) clk_bit(a[i]);
   endtask

   // After a change frame: poll status, wait out programming, poll again
   task automatic poll_status(input bit accepted, input string req);
      sel_up();
      if (accepted) begin
         chk({req, " busy oe"}, 32'(sdout_oe), 1);
         chk({req, " busy level"}, 32'(sdout), 0);
         repeat (PCYC + 10) @(negedge clk_i);
         chk({req, " ready level"}, 32'(sdout), 1);
      end else begin
         chk({req, " no programming"}, 32'(sdout_oe), 0);
      end
      sel_down();
   endtask

   task automatic do_read(input logic [7:0] a, input int nwords, input int lead, input string req);
      logic [15:0] got;
      sel_up();
      for (int i = 0; i < lead; i++) begin
         clk_bit(1'b0);
         chk({req, " lead zero ignored"}, 32'(smp_oe), 32'(ref_stat));
      end
      send_hdr(2'b10, a, 1'b0);
      chk({req, " R5 dummy oe"}, 32'(smp_oe), 1);
      chk({req, " R5 dummy zero"}, 32'(smp_do), 0);
      for (int w = 0; w < nwords; w++) begin
         for (int i = 15; i >= 0; i--) begin
            clk_bit(1'b0);
            got[i] = smp_do;
         end
         chk({req, " data"}, 32'(got), 32'(ref_mem[8'(a + w)]));
      end
      sel_down();
      chk({req, " R4 oe low after select"}, 32'(sdout_oe), 0);
   endtask

   task automatic do_write(input logic [7:0] a, input logic [15:0] d, input logic pe_v,
                           input int drop_at, input string req);
      bit acc;
      acc = will_accept(a, pe_v && (drop_at < 0));
      sel_up();
      send_hdr(2'b01, a, pe_v);
      for (int i = 15; i >= 0; i--) begin
         pgm_ok = pe_v && (i != drop_at);
         clk_bit(d[i]);
      end
      pgm_ok = pe_v;
      sel_down();
      if (acc) begin
         ref_mem[a] = d;
         ref_stat = 1'b1;
      end
      poll_status(acc, req);
   endtask

   task automatic do_erase(input logic [7:0] a, input logic pe_v, input string req);
      bit acc;
      acc = will_accept(a, pe_v);
      sel_up();
      send_hdr(2'b11, a, pe_v);
      sel_down();
      if (acc) begin
         ref_mem[a] = 16'hFFFF;
         ref_stat = 1'b1;
      end
      poll_status(acc, req);
   endtask

   task automatic do_ctrl(input logic unlock, input logic pe_v, input logic [5:0] low);
      sel_up();
      send_hdr(2'b00, {unlock ? 2'b11 : 2'b00, low}, pe_v);
      sel_down();
      if (unlock && pe_v) ref_unl = 1'b1;
      if (!unlock) ref_unl = 1'b0;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk_i);
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin : main
      logic [7:0] ra;
      logic [15:0] rd;
      int unsigned pick;
      for (int i = 0; i < 256; i++) ref_mem[i] = 16'hFFFF;
      void'($urandom(32'h5EED));
      repeat (5) @(negedge clk_i);
      rst_ni = 1'b1;
      repeat (5) @(negedge clk_i);

      // R1 reset state
      chk("R1 oe after reset", 32'(sdout_oe), 0);
      do_read(8'h10, 1, 0, "R1 erased word");
      // R1 R7 locked after reset
      do_write(8'h20, 16'h1234, 1'b1, -1, "R1 R7 write while locked");
      do_read(8'h20, 1, 0, "R7 locked word unchanged");

      // R12 unlock without program-allow does nothing
      do_ctrl(1'b1, 1'b0, 6'h15);
      do_write(8'h21, 16'hBEEF, 1'b1, -1, "R12 unlock needs allow");

      // R3 unlock, write, read back with leading zeros (R2)
      do_ctrl(1'b1, 1'b1, 6'h2A);
      do_write(8'h21, 16'hA5C3, 1'b1, -1, "R9 write accepted");
      do_read(8'h21, 1, 3, "R2 R9 readback");

      // R12 program-allow dropped mid data
      do_write(8'h22, 16'h0F0F, 1'b1, 7, "R12 allow dropped mid frame");
      do_read(8'h22, 1, 0, "R12 word unchanged");

      // R8 protected address
      do_write(8'h02, 16'h0000, 1'b1, -1, "R8 protected write");
      do_erase(8'h03, 1'b1, "R8 protected erase");
      do_read(8'h02, 2, 0, "R8 protected words");

      // R10 erase
      do_write(8'h30, 16'h0001, 1'b1, -1, "R10 pre-write");
      do_erase(8'h30, 1'b1, "R10 erase accepted");
      do_read(8'h30, 1, 0, "R10 erased to ones");

      // R9 aborted frame
      sel_up();
      send_hdr(2'b01, 8'h40, 1'b1);
      for (int i = 0; i < 8; i++) clk_bit(1'b0);
      sel_down();
      poll_status(1'b0, "R9 aborted frame");
      do_read(8'h40, 1, 0, "R9 aborted word unchanged");

      // R13 extra edges after a complete write are ignored
      sel_up();
      send_hdr(2'b01, 8'h41, 1'b1);
      for (int i = 15; i >= 0; i--) clk_bit(1'(16'h3C5A >> i));
      for (int i = 0; i < 3; i++) begin
         clk_bit(1'b1);
         chk("R13 extra edge keeps output off", 32'(smp_oe), 0);
      end
      sel_down();
      ref_mem[8'h41] = 16'h3C5A;
      ref_stat = 1'b1;
      poll_status(1'b1, "R13 write still runs");
      do_read(8'h41, 1, 0, "R13 data intact");

      // R11 start bit ignored while busy
      sel_up();
      send_hdr(2'b01, 8'h50, 1'b1);
      for (int i = 15; i >= 0; i--) clk_bit(1'(16'h7E81 >> i));
      sel_down();
      ref_mem[8'h50] = 16'h7E81;
      ref_stat = 1'b1;
      sel_up();
      clk_bit(1'b1);
      clk_bit(1'b0);
      chk("R11 start ignored while busy oe", 32'(smp_oe), 1);
      chk("R11 start ignored while busy level", 32'(smp_do), 0);
      sel_down();
      repeat (PCYC + 10) @(negedge clk_i);
      do_read(8'h50, 1, 0, "R11 write completed");

      // R6 sequential read with wrap
      do_write(8'hFE, 16'h1111, 1'b1, -1, "R6 setup FE");
      do_write(8'hFF, 16'h2222, 1'b1, -1, "R6 setup FF");
      do_read(8'hFE, 4, 0, "R6 wrap read");

      // R7 lock then write rejected
      do_ctrl(1'b0, 1'b1, 6'h3F);
      do_write(8'h60, 16'h4444, 1'b1, -1, "R7 write after lock");
      do_read(8'h60, 1, 0, "R7 word unchanged after lock");

      // Constrained random mix
      for (int n = 0; n < 45; n++) begin
         pick = $urandom_range(0, 9);
         ra = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 5)) : 8'($urandom_range(4, 15));
         rd = 16'($urandom);
         if (pick < 3) do_write(ra, rd, 1'($urandom_range(0, 5) != 0), -1, "R9 random write");
         else if (pick < 4) do_erase(ra, 1'b1, "R10 random erase");
         else if (pick < 5) do_ctrl(1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 3) != 0),
                                    6'($urandom));
         else do_read(ra, 1 + $urandom_range(0, 2), $urandom_range(0, 2), "R5 random read");
      end

      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule